// File: doc/BRIEF.md
# Shift and Rotate Unit

An execution unit for an 8-bit CPU core that performs the single-bit shift and rotate operations. It takes one data operand, the current carry flag and a 5-bit selector, which is the low five bits of the second byte of a prefixed opcode whose top three bits are `100`. One clock edge later it presents the shifted or rotated result. Alongside the result it gives the new Zero, Carry, Sign and Overflow values, a write-enable mask that names which of those flags the operation may update, and the instruction's cycle count.

The selector is built from two fields. Bits [4:2] pick one of eight operations. Bits [1:0] name the operand form, and that form matters here only through the cycle count. Fetching the operand, accessing memory and writing registers back all belong to the surrounding core. The unit takes a new operation on every cycle in which `op_valid_i` is high. It holds its last outputs while the input is idle.

Top module: `shrot_unit`

## Requirements
- R1: Results appear one clock edge after the edge that samples `op_valid_i` high, with `res_valid_o` high for exactly that cycle. Reset clears every output to zero.
- R2: Selector bits [4:2] choose the operation as follows: 0 arithmetic left shift, 1 logical left shift, 2 arithmetic right shift, 3 logical right shift, 4 left rotate through carry, 5 plain left rotate, 6 right rotate through carry, 7 plain right rotate.
- R3: Both left shifts put the operand shifted up by one into the result, fill bit 0 with 0 and send the old bit 7 to Carry.
- R4: The logical right shift fills bit 7 with 0. The arithmetic right shift copies the old bit 7 into bit 7. Both right shifts send the old bit 0 to Carry.
- R5: Plain rotates put the bit shifted out both into the vacated bit and into Carry.
- R6: Rotates through carry put the incoming `carry_i` into the vacated bit and send the bit shifted out to Carry.
- R7: Zero is 1 exactly when the 8-bit result is 0x00, and Sign equals result bit 7.
- R8: For the arithmetic left shift, Overflow is 1 exactly when bit 7 of the result differs from bit 7 of the operand. For the arithmetic right shift, Overflow is always 0.
- R9: Flag and mask bit positions are 0 Zero, 1 Carry, 2 Overflow, 3 Sign. The mask is 4'b1111 for both arithmetic shifts and 4'b1011 for every other operation. A flag output whose mask bit is 0 reads 0.
- R10: Selector bits [1:0] give the cycle count: 12 for 0 and 1 (register A or B), 20 for 2 (memory at the zero-page register plus an offset) and 16 for 3 (memory addressed by HL).
- R11: While `op_valid_i` is low, changes on `sel_i`, `operand_i` and `carry_i` leave `result_o`, `flags_o`, `flag_we_o` and `cycles_o` unchanged, and `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation request this cycle |
| sel_i | input | 5 | Operation selector, low five bits of the second opcode byte |
| operand_i | input | 8 | Data to shift or rotate |
| carry_i | input | 1 | Current carry flag |
| res_valid_o | output | 1 | Result is presented this cycle |
| result_o | output | 8 | Shifted or rotated value |
| flags_o | output | 4 | New flag values: Zero, Carry, Overflow, Sign at bits 0 to 3 |
| flag_we_o | output | 4 | Which flags the operation updates, same bit positions |
| cycles_o | output | 5 | Instruction cycle count for the operand form |

## Verification
The properties that relate outputs to operands look back one cycle. They therefore assume that the inputs are stable at each sampling edge and that `op_valid_i` is low throughout reset. The bench drives every input only on the falling clock edge and holds `op_valid_i` at 0 until reset is released. It feeds all 32 selector values with operands chosen to flip bit 7, shift out a 1, and produce a zero result, each with both carry values. Idle gaps between requests carry deliberately changed inputs, so the hold behaviour is exercised.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    // Flag bit positions, shared by flags_o and flag_we_o
    localparam int FLAG_N  = 4;
    localparam int FLG_Z   = 0;
    localparam int FLG_C   = 1;
    localparam int FLG_V   = 2;
    localparam int FLG_S   = 3;

    localparam int SEL_W   = 5;

    // Operation, selector bits [4:2]
    typedef enum logic [2:0] {
        K_ASL = 3'd0,
        K_LSL = 3'd1,
        K_ASR = 3'd2,
        K_LSR = 3'd3,
        K_RLC = 3'd4,
        K_ROL = 3'd5,
        K_RRC = 3'd6,
        K_ROR = 3'd7
    } op_kind_e;

    // Operand form, selector bits [1:0]
    typedef enum logic [1:0] {
        F_REG_A = 2'd0,
        F_REG_B = 2'd1,
        F_ZPAGE = 2'd2,
        F_PTRHL = 2'd3
    } opnd_e;

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int REG_CYC = 12,
    parameter int ZP_CYC  = 20,
    parameter int HL_CYC  = 16,
    parameter int CYC_W   = 5
) (
    input  logic [SEL_W-1:0]  sel_i,
    output op_kind_e          kind_o,
    output logic [FLAG_N-1:0] we_o,
    output logic [CYC_W-1:0]  cycles_o
);

    opnd_e form;

    always_comb begin
        kind_o = op_kind_e'(sel_i[4:2]);
        form   = opnd_e'(sel_i[1:0]);

        // Arithmetic shifts own every flag, the rest leave Overflow alone
        we_o        = '1;
        if (!(kind_o == K_ASL || kind_o == K_ASR)) begin
            we_o[FLG_V] = 1'b0;
        end

        case (form)
            F_ZPAGE: cycles_o = CYC_W'(ZP_CYC);
            F_PTRHL: cycles_o = CYC_W'(HL_CYC);
            default: cycles_o = CYC_W'(REG_CYC);
        endcase
    end

endmodule

// File: rtl/shrot_shifter.sv
module shrot_shifter
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_kind_e          kind_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              ovf_o
);

    localparam int MSB = DATA_W - 1;

    logic fill;
    logic go_left;

    always_comb begin
        go_left = !kind_i[1];

        // Bit entering the vacated position
        case (kind_i)
            K_ASR:          fill = opnd_i[MSB];
            K_RLC, K_RRC:   fill = cin_i;
            K_ROL:          fill = opnd_i[MSB];
            K_ROR:          fill = opnd_i[0];
            default:        fill = 1'b0;
        endcase

        if (go_left) begin
            res_o  = {opnd_i[MSB-1:0], fill};
            cout_o = opnd_i[MSB];
        end else begin
            res_o  = {fill, opnd_i[MSB:1]};
            cout_o = opnd_i[0];
        end

        // Sign-bit change; zero for right arithmetic by construction of fill
        ovf_o = res_o[MSB] ^ opnd_i[MSB];
    end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic              cout_i,
    input  logic              ovf_i,
    input  logic [FLAG_N-1:0] we_i,
    output logic [FLAG_N-1:0] flags_o
);

    logic [FLAG_N-1:0] raw;

    always_comb begin
        raw        = '0;
        raw[FLG_Z] = (res_i == '0);
        raw[FLG_C] = cout_i;
        raw[FLG_V] = ovf_i;
        raw[FLG_S] = res_i[DATA_W-1];
        flags_o    = raw & we_i;
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REG_CYC = 12,
    parameter int ZP_CYC  = 20,
    parameter int HL_CYC  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid_i,
    input  logic [SEL_W-1:0]       sel_i,
    input  logic [DATA_W-1:0]      operand_i,
    input  logic                   carry_i,
    output logic                   res_valid_o,
    output logic [DATA_W-1:0]      result_o,
    output logic [FLAG_N-1:0]      flags_o,
    output logic [FLAG_N-1:0]      flag_we_o,
    output logic [4:0]             cycles_o
);

    localparam int MAX_CYC_A = (REG_CYC > ZP_CYC) ? REG_CYC : ZP_CYC;
    localparam int MAX_CYC   = (MAX_CYC_A > HL_CYC) ? MAX_CYC_A : HL_CYC;
    localparam int CYC_W     = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [FLAG_N-1:0] flags;
        logic [FLAG_N-1:0] we;
        logic [CYC_W-1:0]  cycles;
    } state_t;

    state_t st_d, st_q;

    op_kind_e          kind;
    logic [FLAG_N-1:0] we_c;
    logic [CYC_W-1:0]  cyc_c;
    logic [DATA_W-1:0] res_c;
    logic              cout_c;
    logic              ovf_c;
    logic [FLAG_N-1:0] flags_c;

    shrot_decode #(
        .REG_CYC (REG_CYC),
        .ZP_CYC  (ZP_CYC),
        .HL_CYC  (HL_CYC),
        .CYC_W   (CYC_W)
    ) i_decode (
        .sel_i    (sel_i),
        .kind_o   (kind),
        .we_o     (we_c),
        .cycles_o (cyc_c)
    );

    shrot_shifter #(
        .DATA_W (DATA_W)
    ) i_shifter (
        .kind_i (kind),
        .opnd_i (operand_i),
        .cin_i  (carry_i),
        .res_o  (res_c),
        .cout_o (cout_c),
        .ovf_o  (ovf_c)
    );

    shrot_flags #(
        .DATA_W (DATA_W)
    ) i_flags (
        .res_i   (res_c),
        .cout_i  (cout_c),
        .ovf_i   (ovf_c),
        .we_i    (we_c),
        .flags_o (flags_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid_i;
        if (op_valid_i) begin
            st_d.result = res_c;
            st_d.flags  = flags_c;
            st_d.we     = we_c;
            st_d.cycles = cyc_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.valid;
    assign result_o    = st_q.result;
    assign flags_o     = st_q.flags;
    assign flag_we_o   = st_q.we;
    assign cycles_o    = 5'(st_q.cycles);

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
    import shrot_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ZP_CYC = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_valid_i,
    input logic [SEL_W-1:0]       sel_i,
    input logic [DATA_W-1:0]      operand_i,
    input logic                   res_valid_o,
    input logic [DATA_W-1:0]      result_o,
    input logic [FLAG_N-1:0]      flags_o,
    input logic [FLAG_N-1:0]      flag_we_o,
    input logic [4:0]             cycles_o
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> res_valid_o);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !res_valid_o);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(result_o) && $stable(flags_o) && $stable(cycles_o));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> flags_o[FLG_Z] == (result_o == '0));

    // R7
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> flags_o[FLG_S] == result_o[DATA_W-1]);

    // R9
    arith_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && !sel_i[4] && !sel_i[2] |=> flag_we_o == 4'b1111);

    // R9
    logic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && (sel_i[4] || sel_i[2]) |=> flag_we_o == 4'b1011);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && sel_i[4:2] == 3'd2 |=> !flags_o[FLG_V]);

    // R5
    rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && sel_i[4] && sel_i[2]
        |=> $countones(result_o) == $countones($past(operand_i)));

    // R10
    zpage_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && sel_i[1:0] == 2'd2 |=> cycles_o == 5'(ZP_CYC));

endmodule

bind shrot_unit shrot_unit_chk #(
    .DATA_W (DATA_W),
    .ZP_CYC (ZP_CYC)
) i_shrot_unit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid_i),
    .sel_i       (sel_i),
    .operand_i   (operand_i),
    .res_valid_o (res_valid_o),
    .result_o    (result_o),
    .flags_o     (flags_o),
    .flag_we_o   (flag_we_o),
    .cycles_o    (cycles_o)
);

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;

    typedef struct {
        logic [4:0] sel;
        logic [7:0] res;
        logic [3:0] flg;
        logic [3:0] we;
        logic [4:0] cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [4:0] sel_i = '0;
    logic [7:0] operand_i = '0;
    logic       carry_i = 1'b0;
    logic       res_valid_o;
    logic [7:0] result_o;
    logic [3:0] flags_o;
    logic [3:0] flag_we_o;
    logic [4:0] cycles_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    bit   have_last = 1'b0;
    exp_t last;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    shrot_unit i_shrot_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid_i  (op_valid_i),
        .sel_i       (sel_i),
        .operand_i   (operand_i),
        .carry_i     (carry_i),
        .res_valid_o (res_valid_o),
        .result_o    (result_o),
        .flags_o     (flags_o),
        .flag_we_o   (flag_we_o),
        .cycles_o    (cycles_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic exp_t model(logic [4:0] s, logic [7:0] x, logic c);
        exp_t e;
        logic co;
        logic v;
        logic [7:0] r;
        v = 1'b0;
        e.we = 4'b1011;
        case (s[4:2])
            3'd0: begin co = x[7]; r = x << 1; v = x[7] ^ x[6]; e.we = 4'b1111; end
            3'd1: begin co = x[7]; r = x << 1; end
            3'd2: begin co = x[0]; r = {x[7], x[7:1]}; e.we = 4'b1111; end
            3'd3: begin co = x[0]; r = x >> 1; end
            3'd4: begin co = x[7]; r = {x[6:0], c}; end
            3'd5: begin co = x[7]; r = {x[6:0], x[7]}; end
            3'd6: begin co = x[0]; r = {c, x[7:1]}; end
            default: begin co = x[0]; r = {x[0], x[7:1]}; end
        endcase
        e.sel = s;
        e.res = r;
        e.flg = {r[7], v, co, (r == 8'h00)} & e.we;
        e.cyc = (s[1:0] == 2'd2) ? 5'd20 : (s[1:0] == 2'd3) ? 5'd16 : 5'd12;
        return e;
    endfunction

    task automatic drive(input logic [4:0] s, input logic [7:0] x, input logic c);
        @(negedge clk);
        op_valid_i = 1'b1;
        sel_i      = s;
        operand_i  = x;
        carry_i    = c;
        sb.push_back(model(s, x, c));
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            op_valid_i = 1'b0;
            sel_i      = sel_i + 5'd7;
            operand_i  = junk ^ 8'(k);
            carry_i    = ~carry_i;
        end
    endtask

    function automatic string res_tag(logic [4:0] s);
        case (s[4:2])
            3'd0, 3'd1: return "R3 R2";
            3'd2, 3'd3: return "R4 R2";
            3'd5, 3'd7: return "R5 R2";
            default:    return "R6 R2";
        endcase
    endfunction

    // Monitor: sample one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (res_valid_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result_o == e.res, res_tag(e.sel), result_o, e.res);
                    check(flags_o[1] == e.flg[1], res_tag(e.sel), flags_o[1], e.flg[1]);
                    check(flags_o[0] == e.flg[0] && flags_o[3] == e.flg[3],
                          "R7 zero/sign", flags_o, e.flg);
                    check(flags_o[2] == e.flg[2], "R8 overflow", flags_o[2], e.flg[2]);
                    check(flag_we_o == e.we, "R9 mask", flag_we_o, e.we);
                    check(cycles_o == e.cyc, "R10 cycles", cycles_o, e.cyc);
                    last = e;
                    have_last = 1'b1;
                end
            end else if (have_last) begin
                check(result_o == last.res && flags_o == last.flg &&
                      flag_we_o == last.we && cycles_o == last.cyc,
                      "R11 hold", {result_o, flags_o}, {last.res, last.flg});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [8];
        pats = '{8'h00, 8'h80, 8'h01, 8'h40, 8'hC3, 8'hFF, 8'h7F, 8'hA5};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_valid_o == 1'b0 && result_o == 8'h00 && flags_o == 4'h0 &&
              flag_we_o == 4'h0 && cycles_o == 5'd0, "R1 reset", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Back-to-back sweep over every selector
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 8; p++) begin
                for (int c = 0; c < 2; c++) begin
                    drive(5'(s), pats[p], 1'(c));
                end
            end
        end
        // Sparse requests with changing idle inputs (R11)
        for (int s = 0; s < 32; s += 3) begin
            drive(5'(s), 8'h81, 1'b1);
            idle(3, 8'h5A);
        end
        // Zero-result corner cases (R7)
        drive(5'd4, 8'h80, 1'b0);
        drive(5'd12, 8'h01, 1'b0);
        drive(5'd24, 8'h01, 1'b0);
        drive(5'd16, 8'h80, 1'b0);
        idle(4, 8'h33);

        @(negedge clk);
        check(sb.size() == 0, "R1 drained", sb.size(), 0);
        check(res_valid_o == 1'b0, "R1 valid low", res_valid_o, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule